// File: doc/BRIEF.md
# Transparent Scrambling Word RAM

This block is an on-chip word RAM that stores its contents in a scrambled form. A raw dump of the storage array shows neither the data nor where each word lives, while the processor sees ordinary memory. Each access uses two seed inputs. The address seed moves every word to a different physical row. The data seed, together with the unscrambled word address, masks every stored bit. Reads apply the same mask again, so the processor gets its original data back.

The processor side works like a single-cycle synchronous RAM. It presents a select, a word address, byte-lane write strobes and write data. One cycle later the acknowledge rises and the read word is valid. Scrambling adds no cycle. The seeds are sampled on every access, with no latching. If software changes a seed, earlier contents read back as a predictable mixture of old and new masks, and this is accepted. The seed source, its register file, access control and cryptographic strength are outside this block.

Top module: `scramRam`

## Requirements
- R1: The physical row written or read equals the word address XOR the low IDX_W bits of the address seed. The same row is reached from any address and seed pair with the same XOR.
- R2: The word stored in the array equals the write data XOR the data seed XOR the word address zero-extended to DATA_W bits.
- R3: A read returns the stored word XOR the data seed XOR the zero-extended address of that read. With unchanged seeds, it therefore returns the data last written to that address.
- R4: Address-seed bits at positions IDX_W and above have no effect on any access.
- R5: Strobe bit k (bit 0 = data bits 7:0) writes byte lane k of the scrambled word. Unselected lanes keep their stored bytes.
- R6: A selected access raises ack and presents its read word on rdData in the following cycle, with no added latency.
- R7: While cs is low, nothing is written, ack is low in the next cycle and rdData is zero.
- R8: Writing one value at two different addresses, with the same seeds, stores two different array words.
- R9: A selected write returns, in its ack cycle, the descrambled contents the row held before that write.
- R10: After reset and before any access, ack is low and rdData is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Access select |
| wStrb | input | DATA_W/8 | Byte-lane write strobes; all zero means read |
| addr | input | IDX_W | Processor word address |
| wData | input | DATA_W | Write data |
| addrSeed | input | SEED_W | Address permutation seed |
| dataSeed | input | DATA_W | Data masking seed |
| ack | output | 1 | Access completed (one cycle after select) |
| rdData | output | DATA_W | Descrambled read data, zero when ack is low |

## Verification
The bench builds the block with IDX_W = 6, a 64-word array, keeping DATA_W and SEED_W at 32. With this array size, an address seed of all ones flips every index bit, and most address-seed bits lie above the index, which makes the R4 check meaningful. A bench model of the physical array predicts raw contents. Reads made with shifted seeds land on chosen rows with a chosen mask, and this exposes raw stored words for R2 and R8.

// File: rtl/scramPkg.sv
package scramPkg;

  // strobes passed from the control module to the datapath
  typedef struct packed {
    logic access;   // a selected access happens this cycle
    logic rdValid;  // the access of the previous cycle completes now
  } ctrlStrobesT;

endpackage

// File: rtl/scramLane.sv
// One byte lane of the storage array, read-first synchronous port.
module scramLane #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       d,
  output logic [7:0]       q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      q <= mem[idx];
      if (we) mem[idx] <= d;
    end
  end
endmodule

// File: rtl/scramCtrl.sv
module scramCtrl
  import scramPkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cs,
  input  logic [NB-1:0] wStrb,
  output ctrlStrobesT   strobes,
  output logic [NB-1:0] laneWe,
  output logic          ack
);
  logic ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= cs;
  end

  assign ack             = ackQ;
  assign laneWe          = cs ? wStrb : '0;
  assign strobes.access  = cs;
  assign strobes.rdValid = ackQ;

  AST_ACK_AFTER_SEL: assert property (@(posedge clk) disable iff (!rstN)
    cs |=> ack);  // R6
  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> !ack);  // R7
  AST_NO_LANE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.access |-> laneWe == '0);  // R7
endmodule

// File: rtl/scramDatapath.sv
module scramDatapath
  import scramPkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  parameter int SEED_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [NB-1:0]     laneWe,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wData,
  input  logic [SEED_W-1:0] addrSeed,
  input  logic [DATA_W-1:0] dataSeed,
  output logic [DATA_W-1:0] rdData
);
  localparam int NB = DATA_W / 8;

  logic [IDX_W-1:0]  physIdx;
  logic [DATA_W-1:0] wordMask;
  logic [DATA_W-1:0] scramWord;
  logic [DATA_W-1:0] rawQ;
  logic [DATA_W-1:0] maskQ;
  logic              unusedSeedBits;

  // only the low index bits of the address seed take part
  assign physIdx        = addr ^ addrSeed[IDX_W-1:0];
  assign unusedSeedBits = ^addrSeed[SEED_W-1:IDX_W];

  // address-dependent mask, shared by the write and read directions
  assign wordMask  = dataSeed ^ DATA_W'(addr);
  assign scramWord = wData ^ wordMask;

  generate
    for (genvar lane = 0; lane < NB; lane++) begin : gLane
      scramLane #(.IDX_W(IDX_W)) uLane (
        .clk (clk),
        .en  (strobes.access),
        .we  (laneWe[lane]),
        .idx (physIdx),
        .d   (scramWord[lane*8 +: 8]),
        .q   (rawQ[lane*8 +: 8])
      );
    end
  endgenerate

  // the mask of the access is kept for the cycle its word comes back
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskQ <= '0;
    else if (strobes.access) maskQ <= wordMask;
  end

  assign rdData = strobes.rdValid ? (rawQ ^ maskQ) : '0;

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.access |=> $stable(maskQ));  // R3
endmodule

// File: rtl/scramRam.sv
module scramRam
  import scramPkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  parameter int SEED_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cs,
  input  logic [DATA_W/8-1:0]   wStrb,
  input  logic [IDX_W-1:0]      addr,
  input  logic [DATA_W-1:0]     wData,
  input  logic [SEED_W-1:0]     addrSeed,
  input  logic [DATA_W-1:0]     dataSeed,
  output logic                  ack,
  output logic [DATA_W-1:0]     rdData
);
  localparam int NB = DATA_W / 8;

  ctrlStrobesT   strobes;
  logic [NB-1:0] laneWe;

  scramCtrl #(.NB(NB)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cs      (cs),
    .wStrb   (wStrb),
    .strobes (strobes),
    .laneWe  (laneWe),
    .ack     (ack)
  );

  scramDatapath #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SEED_W(SEED_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .laneWe   (laneWe),
    .addr     (addr),
    .wData    (wData),
    .addrSeed (addrSeed),
    .dataSeed (dataSeed),
    .rdData   (rdData)
  );

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !ack |-> rdData == '0);  // R7

  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cs) && $past(wStrb) == '1 && cs && wStrb == '0 &&
     addr == $past(addr) && addrSeed == $past(addrSeed) &&
     dataSeed == $past(dataSeed))
    |=> rdData == $past(wData, 2));  // R3
endmodule

// File: tb/scramRam_test.sv
module scramRam_test;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 32;
  localparam int SEED_W = 32;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int NV     = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cs = 1'b0;
  logic [3:0]        wStrb = '0;
  logic [IDX_W-1:0]  addr = '0;
  logic [DATA_W-1:0] wData = '0;
  logic [SEED_W-1:0] addrSeed = '0;
  logic [DATA_W-1:0] dataSeed = '0;
  logic              ack;
  logic [DATA_W-1:0] rdData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  scramRam #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SEED_W(SEED_W)) uut (
    .clk(clk), .rstN(rstN), .cs(cs), .wStrb(wStrb), .addr(addr),
    .wData(wData), .addrSeed(addrSeed), .dataSeed(dataSeed),
    .ack(ack), .rdData(rdData)
  );

  // stimulus table: one access per row, expected values from the model
  localparam logic       vCs   [NV] = '{1,1,1,1,0,1,1,1,1,1,1,1};
  localparam logic [3:0] vStrb [NV] = '{4'hF,4'h0,4'hF,4'h0,4'hF,4'h0,
                                        4'h5,4'h0,4'h0,4'h0,4'hF,4'h0};
  localparam logic [5:0] vAddr [NV] = '{5,5,12,12,12,12,12,12,12,5,33,33};
  localparam logic [31:0] vData [NV] = '{32'h11223344,0,32'hCAFEF00D,0,
                                         32'hFFFFFFFF,0,32'h00AA00BB,0,0,0,
                                         32'h0,0};
  localparam logic [31:0] vASeed [NV] = '{0,0,32'h3F,32'h3F,32'h3F,32'h3F,
                                          32'h3F,32'h3F,32'hFFFFFF3F,0,7,7};
  localparam logic [31:0] vDSeed [NV] = '{32'hA5A5A5A5,32'hA5A5A5A5,0,0,0,0,
                                          0,0,0,32'h5A5A5A5A,1,1};
  // R3 round trip, R7 idle, R5 lanes, R9 read-first, R4 upper seed, R2 mask
  localparam int vTag [NV] = '{3,3,3,3,7,7,9,5,4,2,6,3};

  logic [31:0] refMem   [DEPTH];
  logic        refKnown [DEPTH];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one access at a falling edge, check it at the next falling edge
  task automatic doAccess(input logic c, input logic [3:0] s, input logic [5:0] a,
                          input logic [31:0] d, input logic [31:0] as,
                          input logic [31:0] ds, input string tag);
    logic [5:0]  phys;
    logic [31:0] mask;
    logic [31:0] nw;
    cs = c; wStrb = s; addr = a; wData = d; addrSeed = as; dataSeed = ds;
    @(negedge clk);
    phys = a ^ as[5:0];                  // R1
    mask = ds ^ {26'b0, a};              // R2
    if (!c) begin
      chk({tag, " ack idle"}, {31'b0, ack}, 32'h0);
      chk({tag, " rdData idle"}, rdData, 32'h0);
    end else begin
      chk({tag, " ack"}, {31'b0, ack}, 32'h1);   // R6
      if (refKnown[phys]) chk({tag, " rdData"}, rdData, refMem[phys] ^ mask);
      if (s != 4'h0) begin
        nw = refMem[phys];
        for (int k = 0; k < 4; k++)
          if (s[k]) nw[k*8 +: 8] = d[k*8 +: 8] ^ mask[k*8 +: 8];
        refMem[phys] = nw;
        if (s == 4'hF) refKnown[phys] = 1'b1;
      end
    end
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected<20000", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rawA;
    logic [31:0] rawB;
    for (int i = 0; i < DEPTH; i++) begin
      refMem[i] = '0;
      refKnown[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 ack", {31'b0, ack}, 32'h0);
    chk("R10 rdData", rdData, 32'h0);

    for (int i = 0; i < NV; i++)
      doAccess(vCs[i], vStrb[i], vAddr[i], vData[i], vASeed[i], vDSeed[i],
               $sformatf("R%0d vec%0d", vTag[i], i));

    // R1: same physical row reached from another address/seed pair
    doAccess(1, 4'h0, 6'd51, 0, 32'h0, 32'h0, "R1 alias");
    chk("R1 alias value", rdData, 32'hCAAAF0BB ^ 32'h3F);

    // R8: same value at two addresses, raw words exposed via seed=row, addr 0
    doAccess(1, 4'hF, 6'd1, 32'h12345678, 0, 0, "R8 wr1");
    doAccess(1, 4'hF, 6'd2, 32'h12345678, 0, 0, "R8 wr2");
    doAccess(1, 4'h0, 6'd0, 0, 32'h1, 0, "R8 raw1");
    rawA = rdData;
    doAccess(1, 4'h0, 6'd0, 0, 32'h2, 0, "R8 raw2");
    rawB = rdData;
    chk("R8 raw1 value", rawA, 32'h12345679);   // R2
    chk("R8 raw2 value", rawB, 32'h1234567A);
    chk("R8 differ", {31'b0, rawA != rawB}, 32'h1);

    // R7: idle cycle after traffic, then row 1 still intact
    doAccess(0, 4'hF, 6'd1, 32'hDEADBEEF, 0, 0, "R7 idle write");
    doAccess(1, 4'h0, 6'd1, 0, 0, 0, "R7 intact");
    chk("R7 intact value", rdData, 32'h12345678);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule